// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Select

This block chooses, every cycle, which ready instructions leave the scheduling window for execution. Ready instructions arrive one per cycle, each tagged with an operation class, a sequence number (lower means older) and a flag saying it was squashed after becoming ready. Each class keeps its own small ready queue whose head is always its oldest member. The heads of all classes are ranked by age, and the select logic issues up to two of them per cycle, oldest first, provided the execute stage is not stalled and the class's functional unit is free.

Class 0 covers work that needs no functional unit. Classes 1 to 3 each own one unit with a completion timer. An operation of latency one goes straight to execute and its unit is usable again next cycle. A longer operation raises a completion pulse later. On a pipelined unit (issue latency of one or less) that pulse comes one cycle after issue and the unit is free again next cycle. On a non-pipelined unit the pulse comes issue-latency minus one cycles after issue, and the unit stays blocked until the cycle after that pulse. Squashed heads are thrown away without using an issue slot, and a class that loses its turn because its unit is busy is reported.

Top module: `age_issue_select`

## Requirements
- R1: After reset every queue is empty, no issue slot or completion is valid, no discard or busy pulse is raised, and every queue-full flag is low.
- R2: An entry offered with `enqValid` is stored in the queue of class `enqClass` and can be selected from the next cycle on. The head of a class is its lowest sequence number, so an older entry arriving later overtakes the entries already waiting.
- R3: Issuing classes are placed in the issue slots in increasing order of their head sequence number, slot 0 carrying the oldest.
- R4: At most 2 instructions issue per cycle. Each class acts on at most its head entry per cycle.
- R5: While `execStall` is high, nothing issues and nothing is discarded.
- R6: A squashed head is removed in the cycle it is head and `execStall` is low. Its class bit in `discardMask` is set for that cycle, and it takes no issue slot.
- R7: Class 0 issues without a unit. A class 1 to 3 head issues only if its unit is free and its `unitAvail` bit is 1. Otherwise, when fewer than 2 older heads are issuable, its `busyMask` bit is set for that cycle and it waits.
- R8: An issue whose class has operation latency 1 (or is class 0) has `issueDirect` = 1 and raises no completion. Its unit can issue again the next cycle.
- R9: With operation latency above 1 and issue latency 0 or 1, `issueDirect` = 0. The class's `complValid` bit rises with the issued sequence number on `complSeq` one cycle after issue, and the unit can issue again the next cycle.
- R10: With operation latency above 1 and issue latency L > 1, completion is signalled L-1 cycles after issue. The unit stays busy up to and including that cycle and is free in the next.
- R11: When a class queue holds DEPTH entries its `queueFull` bit is 1 and a further entry offered to that class is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | A ready entry is offered this cycle |
| enqClass | input | 2 | Operation class of the offered entry |
| enqSeq | input | SEQ_W | Sequence number of the offered entry |
| enqSquashed | input | 1 | Offered entry is squashed |
| queueFull | output | 4 | Per-class queue full flag |
| unitAvail | input | 4 | Per-class external unit availability (bit 0 ignored) |
| opLat | input | 4*LAT_W | Per-class operation latency, class c at bits [c*LAT_W +: LAT_W] |
| issueLat | input | 4*LAT_W | Per-class issue latency, same layout |
| execStall | input | 1 | Execute stage cannot accept instructions |
| issueValid | output | 2 | Issue slot valid, slot 0 oldest |
| issueSeq | output | 2*SEQ_W | Sequence number per slot |
| issueClass | output | 4 | Class per slot, 2 bits each |
| issueDirect | output | 2 | Slot goes straight to execute (single-cycle) |
| complValid | output | 4 | Per-class completion pulse |
| complSeq | output | 4*SEQ_W | Sequence number of the completing operation per class |
| discardMask | output | 4 | Classes whose squashed head is discarded this cycle |
| busyMask | output | 4 | Classes skipped this cycle because their unit is not free |

## Verification
The hardest state to reach from the ports is several classes holding ready heads at once, in an age order that differs from the arrival order. Without help the block would issue each entry in the cycle after it arrives. The stimulus therefore holds `execStall` high while it loads the queues, offering older entries after younger ones and squashed entries ahead of live ones, and then releases the stall. This exposes the age ranking, the two-slot cut-off and discards that take no slot all in the same cycle. Unit occupancy is set up the same way: two back-to-back entries of one class with chosen latencies show when the unit becomes free again and when the completion pulse appears.

// File: rtl/isq_pkg.sv
package isq_pkg;
  parameter int ISQ_CLASSES = 4;
  parameter int ISQ_WIDTH = 2;
  localparam int ISQ_CLASS_W = $clog2(ISQ_CLASSES);

  typedef struct packed {
    logic [ISQ_CLASSES-1:0] issue;
    logic [ISQ_CLASSES-1:0] discard;
    logic [ISQ_CLASSES-1:0] arm;
  } isq_strobe_t;
endpackage

// File: rtl/isq_class_queue.sv
module isq_class_queue #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enq,
  input  logic [SEQ_W-1:0] enqSeq,
  input  logic             enqSquashed,
  input  logic             pop,
  output logic             headValid,
  output logic [SEQ_W-1:0] headSeq,
  output logic             headSquashed,
  output logic             full
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] slotVld;
  logic [DEPTH-1:0] slotSq;
  logic [SEQ_W-1:0] slotSeq [DEPTH];
  logic [IDX_W-1:0] headIdx;
  logic [IDX_W-1:0] freeIdx;

  // oldest valid entry is the head
  always_comb begin
    headValid = 1'b0;
    headIdx = '0;
    headSeq = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slotVld[i] && (!headValid || slotSeq[i] < headSeq)) begin
        headValid = 1'b1;
        headIdx = IDX_W'(i);
        headSeq = slotSeq[i];
      end
    end
    headSquashed = headValid & slotSq[headIdx];
  end

  always_comb begin
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slotVld[i]) freeIdx = IDX_W'(i);
    end
  end

  assign full = &slotVld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotVld <= '0;
      slotSq <= '0;
      for (int i = 0; i < DEPTH; i++) slotSeq[i] <= '0;
    end else begin
      if (pop) slotVld[headIdx] <= 1'b0;
      if (enq && !full) begin
        slotVld[freeIdx] <= 1'b1;
        slotSeq[freeIdx] <= enqSeq;
        slotSq[freeIdx] <= enqSquashed;
      end
    end
  end

  // R6 / R2: a pop only ever removes an existing head
  a_r2_pop_has_head: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> headValid);
  // R11: a dropped entry leaves the queue full
  a_r11_full_stays: assert property (@(posedge clk) disable iff (!rstN)
    (full && enq && !pop) |=> full);
endmodule

// File: rtl/isq_unit_timer.sv
module isq_unit_timer #(
  parameter int SEQ_W = 8,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [SEQ_W-1:0] loadSeq,
  input  logic [LAT_W-1:0] issueLat,
  output logic             unitFree,
  output logic             complValid,
  output logic [SEQ_W-1:0] complSeq
);
  logic             active;
  logic             holdUnit;
  logic [LAT_W-1:0] cnt;
  logic [SEQ_W-1:0] seqR;

  assign complValid = active && (cnt == LAT_W'(1));
  assign unitFree = !(active && holdUnit);
  assign complSeq = seqR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      holdUnit <= 1'b0;
      cnt <= '0;
      seqR <= '0;
    end else if (load) begin
      active <= 1'b1;
      holdUnit <= (issueLat > LAT_W'(1));
      cnt <= (issueLat > LAT_W'(1)) ? LAT_W'(issueLat - 1'b1) : LAT_W'(1);
      seqR <= loadSeq;
    end else if (active) begin
      if (cnt == LAT_W'(1)) active <= 1'b0;
      cnt <= cnt - 1'b1;
    end
  end

  // R10: the select logic never starts an op on a held unit
  a_r10_no_load_when_held: assert property (@(posedge clk) disable iff (!rstN)
    load |-> unitFree);
  // R9: one completion pulse per started operation
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (complValid && !load) |=> !complValid);
endmodule

// File: rtl/isq_datapath.sv
module isq_datapath
  import isq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int LAT_W = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         enqValid,
  input  logic [ISQ_CLASS_W-1:0]       enqClass,
  input  logic [SEQ_W-1:0]             enqSeq,
  input  logic                         enqSquashed,
  input  isq_strobe_t                  strobe,
  input  logic [ISQ_CLASSES*LAT_W-1:0] issueLat,
  input  logic [ISQ_CLASSES-1:0]       unitAvail,
  input  logic [ISQ_CLASSES*SEQ_W-1:0] issueSeqPerClass,
  output logic [ISQ_CLASSES-1:0]       headValid,
  output logic [ISQ_CLASSES*SEQ_W-1:0] headSeq,
  output logic [ISQ_CLASSES-1:0]       headSquashed,
  output logic [ISQ_CLASSES-1:0]       queueFull,
  output logic [ISQ_CLASSES-1:0]       unitFree,
  output logic [ISQ_CLASSES-1:0]       complValid,
  output logic [ISQ_CLASSES*SEQ_W-1:0] complSeq
);
  logic [ISQ_CLASSES-1:0] timerFree;

  for (genvar c = 0; c < ISQ_CLASSES; c++) begin : g_class
    isq_class_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) uQueue (
      .clk(clk),
      .rstN(rstN),
      .enq(enqValid && (enqClass == ISQ_CLASS_W'(c))),
      .enqSeq(enqSeq),
      .enqSquashed(enqSquashed),
      .pop(strobe.issue[c] | strobe.discard[c]),
      .headValid(headValid[c]),
      .headSeq(headSeq[c*SEQ_W +: SEQ_W]),
      .headSquashed(headSquashed[c]),
      .full(queueFull[c])
    );

    isq_unit_timer #(.SEQ_W(SEQ_W), .LAT_W(LAT_W)) uTimer (
      .clk(clk),
      .rstN(rstN),
      .load(strobe.arm[c]),
      .loadSeq(issueSeqPerClass[c*SEQ_W +: SEQ_W]),
      .issueLat(issueLat[c*LAT_W +: LAT_W]),
      .unitFree(timerFree[c]),
      .complValid(complValid[c]),
      .complSeq(complSeq[c*SEQ_W +: SEQ_W])
    );

    // class 0 needs no unit at all
    assign unitFree[c] = (c == 0) ? 1'b1 : (timerFree[c] & unitAvail[c]);
  end

  // R7: an issue on a unit class only happens when that unit is free
  a_r7_issue_needs_unit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue & ~unitFree) == '0);
  // R4: issue and discard never hit the same class in one cycle
  a_r4_one_action: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue & strobe.discard) == '0);
endmodule

// File: rtl/isq_select_ctrl.sv
module isq_select_ctrl
  import isq_pkg::*;
#(
  parameter int SEQ_W = 8,
  parameter int LAT_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [ISQ_CLASSES-1:0]           headValid,
  input  logic [ISQ_CLASSES*SEQ_W-1:0]     headSeq,
  input  logic [ISQ_CLASSES-1:0]           headSquashed,
  input  logic [ISQ_CLASSES-1:0]           unitFree,
  input  logic [ISQ_CLASSES*LAT_W-1:0]     opLat,
  input  logic                             execStall,
  output isq_strobe_t                      strobe,
  output logic [ISQ_CLASSES-1:0]           busyMask,
  output logic [ISQ_WIDTH-1:0]             issueValid,
  output logic [ISQ_WIDTH*SEQ_W-1:0]       issueSeq,
  output logic [ISQ_WIDTH*ISQ_CLASS_W-1:0] issueClass,
  output logic [ISQ_WIDTH-1:0]             issueDirect
);
  localparam int C = ISQ_CLASSES;
  localparam int W = ISQ_WIDTH;
  localparam int CW = ISQ_CLASS_W;
  localparam int CNT_W = $clog2(C + 1);

  logic [C-1:0]     eligible;
  logic [C-1:0]     issueMask;
  logic [C-1:0]     discardMask;
  logic [C-1:0]     directMask;
  logic [CNT_W-1:0] olderElig [C];

  always_comb begin
    for (int c = 0; c < C; c++) begin
      eligible[c] = headValid[c] && !headSquashed[c] && ((c == 0) || unitFree[c]);
      directMask[c] = (c == 0) || (opLat[c*LAT_W +: LAT_W] <= LAT_W'(1));
    end
  end

  // rank: number of issuable heads older than this class's head
  always_comb begin
    for (int c = 0; c < C; c++) begin
      olderElig[c] = '0;
      for (int d = 0; d < C; d++) begin
        if (d != c && eligible[d] &&
            ((headSeq[d*SEQ_W +: SEQ_W] < headSeq[c*SEQ_W +: SEQ_W]) ||
             ((headSeq[d*SEQ_W +: SEQ_W] == headSeq[c*SEQ_W +: SEQ_W]) && d < c)))
          olderElig[c] = olderElig[c] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < C; c++) begin
      issueMask[c] = !execStall && eligible[c] && (olderElig[c] < CNT_W'(W));
      discardMask[c] = !execStall && headValid[c] && headSquashed[c];
      busyMask[c] = !execStall && headValid[c] && !headSquashed[c] && (c != 0) &&
                    !unitFree[c] && (olderElig[c] < CNT_W'(W));
    end
  end

  assign strobe.issue = issueMask;
  assign strobe.discard = discardMask;
  assign strobe.arm = issueMask & ~directMask;

  always_comb begin
    issueValid = '0;
    issueSeq = '0;
    issueClass = '0;
    issueDirect = '0;
    for (int k = 0; k < W; k++) begin
      for (int c = 0; c < C; c++) begin
        if (issueMask[c] && olderElig[c] == CNT_W'(k)) begin
          issueValid[k] = 1'b1;
          issueSeq[k*SEQ_W +: SEQ_W] = headSeq[c*SEQ_W +: SEQ_W];
          issueClass[k*CW +: CW] = CW'(c);
          issueDirect[k] = directMask[c];
        end
      end
    end
  end

  // R4: never more than the issue width
  a_r4_width_limit: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobe.issue) <= W);
  // R3: slots are filled oldest first and without gaps
  a_r3_slot_order: assert property (@(posedge clk) disable iff (!rstN)
    issueValid[1] |-> (issueValid[0] && issueSeq[0 +: SEQ_W] <= issueSeq[SEQ_W +: SEQ_W]));
  // R5: stall silences the slots
  a_r5_stall_quiet: assert property (@(posedge clk) disable iff (!rstN)
    execStall |-> (issueValid == '0));
endmodule

// File: rtl/age_issue_select.sv
module age_issue_select
  import isq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int LAT_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             enqValid,
  input  logic [ISQ_CLASS_W-1:0]           enqClass,
  input  logic [SEQ_W-1:0]                 enqSeq,
  input  logic                             enqSquashed,
  output logic [ISQ_CLASSES-1:0]           queueFull,
  input  logic [ISQ_CLASSES-1:0]           unitAvail,
  input  logic [ISQ_CLASSES*LAT_W-1:0]     opLat,
  input  logic [ISQ_CLASSES*LAT_W-1:0]     issueLat,
  input  logic                             execStall,
  output logic [ISQ_WIDTH-1:0]             issueValid,
  output logic [ISQ_WIDTH*SEQ_W-1:0]       issueSeq,
  output logic [ISQ_WIDTH*ISQ_CLASS_W-1:0] issueClass,
  output logic [ISQ_WIDTH-1:0]             issueDirect,
  output logic [ISQ_CLASSES-1:0]           complValid,
  output logic [ISQ_CLASSES*SEQ_W-1:0]     complSeq,
  output logic [ISQ_CLASSES-1:0]           discardMask,
  output logic [ISQ_CLASSES-1:0]           busyMask
);
  isq_strobe_t                  strobe;
  logic [ISQ_CLASSES-1:0]       headValid;
  logic [ISQ_CLASSES*SEQ_W-1:0] headSeq;
  logic [ISQ_CLASSES-1:0]       headSquashed;
  logic [ISQ_CLASSES-1:0]       unitFree;

  isq_datapath #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .LAT_W(LAT_W)) uData (
    .clk(clk),
    .rstN(rstN),
    .enqValid(enqValid),
    .enqClass(enqClass),
    .enqSeq(enqSeq),
    .enqSquashed(enqSquashed),
    .strobe(strobe),
    .issueLat(issueLat),
    .unitAvail(unitAvail),
    .issueSeqPerClass(headSeq),
    .headValid(headValid),
    .headSeq(headSeq),
    .headSquashed(headSquashed),
    .queueFull(queueFull),
    .unitFree(unitFree),
    .complValid(complValid),
    .complSeq(complSeq)
  );

  isq_select_ctrl #(.SEQ_W(SEQ_W), .LAT_W(LAT_W)) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .headValid(headValid),
    .headSeq(headSeq),
    .headSquashed(headSquashed),
    .unitFree(unitFree),
    .opLat(opLat),
    .execStall(execStall),
    .strobe(strobe),
    .busyMask(busyMask),
    .issueValid(issueValid),
    .issueSeq(issueSeq),
    .issueClass(issueClass),
    .issueDirect(issueDirect)
  );

  assign discardMask = strobe.discard;

  // R6: a discard never coincides with a stall
  a_r6_discard_not_stalled: assert property (@(posedge clk) disable iff (!rstN)
    execStall |-> (discardMask == '0));
endmodule

// File: tb/age_issue_select_test.sv
module age_issue_select_test;
  localparam int SEQ_W = 8;
  localparam int LAT_W = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enqValid = 1'b0;
  logic [1:0]  enqClass = '0;
  logic [7:0]  enqSeq = '0;
  logic        enqSquashed = 1'b0;
  logic [3:0]  queueFull;
  logic [3:0]  unitAvail = 4'b1111;
  logic [15:0] opLat = 16'h1111;
  logic [15:0] issueLat = 16'h1111;
  logic        execStall = 1'b1;
  logic [1:0]  issueValid;
  logic [15:0] issueSeq;
  logic [3:0]  issueClass;
  logic [1:0]  issueDirect;
  logic [3:0]  complValid;
  logic [31:0] complSeq;
  logic [3:0]  discardMask;
  logic [3:0]  busyMask;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  age_issue_select #(.DEPTH(4), .SEQ_W(SEQ_W), .LAT_W(LAT_W)) uut (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqClass(enqClass),
    .enqSeq(enqSeq), .enqSquashed(enqSquashed), .queueFull(queueFull),
    .unitAvail(unitAvail), .opLat(opLat), .issueLat(issueLat),
    .execStall(execStall), .issueValid(issueValid), .issueSeq(issueSeq),
    .issueClass(issueClass), .issueDirect(issueDirect), .complValid(complValid),
    .complSeq(complSeq), .discardMask(discardMask), .busyMask(busyMask)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int cls, input int seq, input bit sq);
    @(negedge clk);
    enqValid = 1'b1;
    enqClass = 2'(cls);
    enqSeq = 8'(seq);
    enqSquashed = sq;
    @(negedge clk);
    enqValid = 1'b0;
    enqSquashed = 1'b0;
  endtask

  task automatic release_stall();
    @(negedge clk);
    execStall = 1'b0;
    #1;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    execStall = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 issueValid", int'(issueValid), 0);
    chk("R1 complValid", int'(complValid), 0);
    chk("R1 queueFull", int'(queueFull), 0);
    chk("R1 discard/busy", int'({discardMask, busyMask}), 0);
  endtask

  task automatic t_age_order();
    push(1, 20, 0); push(2, 10, 0); push(3, 30, 0); push(0, 15, 0);
    #1;
    chk("R5 stalled no issue", int'(issueValid), 0);
    release_stall();
    chk("R4 two slots", int'(issueValid), 3);
    chk("R3 slot0 seq", int'(issueSeq[7:0]), 10);
    chk("R3 slot0 class", int'(issueClass[1:0]), 2);
    chk("R3 slot1 seq", int'(issueSeq[15:8]), 15);
    chk("R7 slot1 class0", int'(issueClass[3:2]), 0);
    chk("R8 direct", int'(issueDirect), 3);
    next_cycle();
    chk("R3 second slot0", int'(issueSeq[7:0]), 20);
    chk("R3 second slot1", int'(issueSeq[15:8]), 30);
    next_cycle();
    chk("R2 queues drained", int'(issueValid), 0);
    settle();
  endtask

  task automatic t_squash();
    push(1, 40, 1); push(1, 41, 0); push(2, 42, 0); push(3, 43, 0);
    #1;
    chk("R5 no discard while stalled", int'(discardMask), 0);
    release_stall();
    chk("R6 discard class1", int'(discardMask), 4'b0010);
    chk("R6 no slot used", int'(issueValid), 3);
    chk("R6 slot0 42", int'(issueSeq[7:0]), 42);
    chk("R6 slot1 43", int'(issueSeq[15:8]), 43);
    next_cycle();
    chk("R6 next live 41", int'(issueSeq[7:0]), 41);
    chk("R6 discard done", int'(discardMask), 0);
    settle();
  endtask

  task automatic t_older_arrival();
    push(1, 60, 0); push(2, 55, 0); push(1, 50, 0);
    release_stall();
    chk("R2 older head slot0", int'(issueSeq[7:0]), 50);
    chk("R2 slot1 55", int'(issueSeq[15:8]), 55);
    next_cycle();
    chk("R2 younger later", int'(issueSeq[7:0]), 60);
    settle();
  endtask

  task automatic t_nonpipe();
    opLat[7:4] = 4'd3; issueLat[7:4] = 4'd3;
    push(1, 70, 0); push(1, 71, 0);
    release_stall();
    chk("R10 issue 70", int'(issueSeq[7:0]), 70);
    chk("R10 not direct", int'(issueDirect[0]), 0);
    next_cycle();
    chk("R10 held unit", int'(issueValid), 0);
    chk("R7 busy pulse", int'(busyMask), 4'b0010);
    chk("R10 no early completion", int'(complValid), 0);
    next_cycle();
    chk("R10 completion", int'(complValid), 4'b0010);
    chk("R10 completion seq", int'(complSeq[15:8]), 70);
    chk("R10 still held", int'(issueValid), 0);
    next_cycle();
    chk("R10 freed issue 71", int'(issueSeq[7:0]), 71);
    chk("R10 freed valid", int'(issueValid), 1);
    repeat (3) next_cycle();
    opLat[7:4] = 4'd1; issueLat[7:4] = 4'd1;
    settle();
  endtask

  task automatic t_pipe();
    opLat[11:8] = 4'd4; issueLat[11:8] = 4'd1;
    push(2, 80, 0); push(2, 81, 0);
    release_stall();
    chk("R9 issue 80", int'(issueSeq[7:0]), 80);
    chk("R9 not direct", int'(issueDirect[0]), 0);
    next_cycle();
    chk("R9 completion", int'(complValid), 4'b0100);
    chk("R9 completion seq", int'(complSeq[23:16]), 80);
    chk("R9 back-to-back issue", int'(issueSeq[7:0]), 81);
    chk("R9 no busy", int'(busyMask), 0);
    next_cycle();
    chk("R9 second completion", int'(complSeq[23:16]), 81);
    chk("R9 second valid", int'(complValid), 4'b0100);
    opLat[11:8] = 4'd1;
    settle();
  endtask

  task automatic t_unitless();
    push(0, 90, 0); push(1, 91, 0);
    unitAvail = 4'b0000;
    release_stall();
    chk("R7 class0 without unit", int'(issueValid), 1);
    chk("R7 class0 seq", int'(issueSeq[7:0]), 90);
    chk("R7 class1 busy", int'(busyMask), 4'b0010);
    @(negedge clk);
    unitAvail = 4'b1111;
    #1;
    chk("R7 class1 issues", int'(issueSeq[7:0]), 91);
    settle();
  endtask

  task automatic t_full();
    push(3, 100, 0); push(3, 101, 0); push(3, 102, 0); push(3, 103, 0);
    #1;
    chk("R11 full flag", int'(queueFull), 4'b1000);
    push(3, 104, 0);
    release_stall();
    chk("R11 first 100", int'(issueSeq[7:0]), 100);
    for (int i = 1; i < 4; i++) begin
      next_cycle();
      chk("R11 drain order", int'(issueSeq[7:0]), 100 + i);
    end
    next_cycle();
    chk("R11 dropped entry absent", int'(issueValid), 0);
    chk("R11 full cleared", int'(queueFull), 0);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_age_order();
    t_squash();
    t_older_arrival();
    t_nonpipe();
    t_pipe();
    t_unitless();
    t_full();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule